// File: doc/BRIEF.md
# Harvest-Aware Power Mode Sequencer

This block is the digital control core of a battery-backed, energy-harvesting power manager. It reads comparator flags from the analog side: battery high and battery low, light or harvest available, converter output low and output high, and one compare result for each harvester connection configuration. From these it drives the system power mode, the two supply enables, the power-on-reset release, the harvester connection and the converter ratio. All of its timing counts a slow tick enable, so the phase lengths are parameters given in ticks.

The block protects the battery. It keeps the system off until the battery has stayed high for a set number of ticks. It then releases the high-voltage supply, then the low-voltage supply, and finally reset. If the battery sags, everything shuts off and the block waits in deep sleep. When harvest energy appears it moves to recovery and recharges the battery. While operational or recovering, it repeats a monitor-then-harvest cycle. At the end of each monitor window it chooses which of the ranked harvester configurations to connect. Separately, it sets the converter ratio from the output-voltage flags, with hysteresis.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, pwr_mode is 2'b00 (start), both supply enables are low, por_n is low, harv_monitor and harv_connect are low, harv_cfg is 0 and ratio_div5 is 0 (divide-by-6).
- R2: In start or recovery, the release sequence begins only after the synchronized battery-high flag has been seen on STABLE_TICKS consecutive ticks. A drop of the flag clears the count.
- R3: The release sequence first raises hv_supply_en. REL_TICKS ticks later it raises lv_supply_en. REL_TICKS ticks after that it raises por_n, and pwr_mode becomes 2'b01 (operational). pwr_mode reads 2'b00 during the release.
- R4: A battery-low flag during release or operational mode forces deep sleep (pwr_mode 2'b10). Deep sleep drops both supplies, asserts reset and disconnects the harvester, whatever phase the harvest cycle is in.
- R5: Deep sleep moves to recovery (pwr_mode 2'b11) only while harvest is reported available. Recovery falls back to deep sleep if availability is lost. The supplies stay off in both modes.
- R6: In operational and recovery modes, a harvest cycle runs from the moment the mode is entered. It starts with MON_TICKS ticks of monitoring (harv_monitor high, harvester disconnected), follows with HARV_TICKS ticks of harvesting, and then repeats.
- R7: Configurations are indexed 0 to N_CFG-1 in order of rising imposed harvest voltage. Flag i means configuration i's fractional voltage is above its compare level. On the last monitor tick the highest set index is latched. That index drives harv_cfg with harv_connect high for the whole harvest phase, even if the flags change.
- R8: If no flag is set at the end of monitoring, harv_connect stays low and harv_cfg stays 0 for that harvest phase.
- R9: ratio_div5 is set when the output-low flag is seen and cleared when the output-high flag is seen. It holds its value when neither flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle slow time-base enable, synchronous to clk |
| batt_hi_a | input | 1 | Battery above the high threshold (asynchronous) |
| batt_lo_a | input | 1 | Battery below the protection threshold (asynchronous) |
| harv_avail_a | input | 1 | Harvest energy available (asynchronous) |
| vout_lo_a | input | 1 | Converter output below its low threshold (asynchronous) |
| vout_hi_a | input | 1 | Converter output above its high threshold (asynchronous) |
| cfg_above_a | input | N_CFG | Per-configuration compare result (asynchronous) |
| pwr_mode | output | 2 | 00 start, 01 operational, 10 deep sleep, 11 recovery |
| hv_supply_en | output | 1 | High-voltage supply enable |
| lv_supply_en | output | 1 | Low-voltage supply enable |
| por_n | output | 1 | Active-low system reset |
| harv_monitor | output | 1 | Monitor phase, harvester held open-circuit |
| harv_connect | output | 1 | Harvester connected to the battery converter |
| harv_cfg | output | CFGW | Selected configuration index |
| ratio_div5 | output | 1 | 1 selects divide-by-5, 0 selects divide-by-6 |

## Verification
A corrupted mode register shows at once as a wrong pwr_mode code or as a wrong pattern of supply enables and por_n. The checks compare all of these together after each step. A wrong tick count in the stability, release or harvest counters shows as a transition one tick early or late. The bench samples just before and just after each expected boundary. A bad latch of the selected configuration shows as harv_cfg moving within a harvest phase, or as the wrong index on the first cycle of the phase. The ratio flop is checked in the hold band between thresholds, where a missing hysteresis shows up at once.

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int N_CFG        = 3,
  parameter int STABLE_TICKS = 8,
  parameter int REL_TICKS    = 2,
  parameter int MON_TICKS    = 44,
  parameter int HARV_TICKS   = 264
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  batt_hi_a,
  input  logic                  batt_lo_a,
  input  logic                  harv_avail_a,
  input  logic                  vout_lo_a,
  input  logic                  vout_hi_a,
  input  logic [N_CFG-1:0]      cfg_above_a,
  output logic [1:0]            pwr_mode,
  output logic                  hv_supply_en,
  output logic                  lv_supply_en,
  output logic                  por_n,
  output logic                  harv_monitor,
  output logic                  harv_connect,
  output logic [((N_CFG>1)?$clog2(N_CFG):1)-1:0] harv_cfg,
  output logic                  ratio_div5
);

  localparam int CFGW   = (N_CFG > 1) ? $clog2(N_CFG) : 1;
  localparam int SYW    = 5 + N_CFG;
  localparam int SMAX   = (STABLE_TICKS > REL_TICKS) ? STABLE_TICKS : REL_TICKS;
  localparam int SCW    = $clog2(SMAX + 1);
  localparam int HMAX   = (MON_TICKS > HARV_TICKS) ? MON_TICKS : HARV_TICKS;
  localparam int HCW    = $clog2(HMAX + 1);
  localparam logic [SCW-1:0] STAB_LAST = SCW'(STABLE_TICKS - 1);
  localparam logic [SCW-1:0] REL_LAST  = SCW'(REL_TICKS - 1);
  localparam logic [HCW-1:0] MON_LAST  = HCW'(MON_TICKS - 1);
  localparam logic [HCW-1:0] HARV_LAST = HCW'(HARV_TICKS - 1);

  typedef enum logic [2:0] {
    S_START, S_RELHV, S_RELLV, S_OPER, S_DSLEEP, S_RECOV
  } st_t;

  logic [SYW-1:0] sy1, sy2;
  logic bhi_s, blo_s, hav_s, vlo_s, vhi_s;
  logic [N_CFG-1:0] cfg_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= {cfg_above_a, vout_hi_a, vout_lo_a, harv_avail_a, batt_lo_a, batt_hi_a};
      sy2 <= sy1;
    end

  assign {cfg_s, vhi_s, vlo_s, hav_s, blo_s, bhi_s} = sy2;

  st_t st;
  logic [SCW-1:0] scnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_START;
      scnt <= '0;
    end else begin
      case (st)
        S_START, S_RECOV:
          if (st == S_RECOV && !hav_s) begin
            st   <= S_DSLEEP;
            scnt <= '0;
          end else if (!bhi_s) begin
            scnt <= '0;
          end else if (tick) begin
            if (scnt == STAB_LAST) begin
              st   <= S_RELHV;
              scnt <= '0;
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
        S_RELHV, S_RELLV:
          if (blo_s) begin
            st   <= S_DSLEEP;
            scnt <= '0;
          end else if (tick) begin
            if (scnt == REL_LAST) begin
              st   <= (st == S_RELHV) ? S_RELLV : S_OPER;
              scnt <= '0;
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
        S_OPER:
          if (blo_s) begin
            st   <= S_DSLEEP;
            scnt <= '0;
          end
        S_DSLEEP:
          if (hav_s) begin
            st   <= S_RECOV;
            scnt <= '0;
          end
        default: begin
          st   <= S_START;
          scnt <= '0;
        end
      endcase
    end

  logic loop_on, in_harv, sel_ok;
  logic [HCW-1:0] hcnt;
  logic [CFGW-1:0] sel_cfg, pick;
  logic any_set;

  assign loop_on = (st == S_OPER) || (st == S_RECOV);

  always_comb begin
    pick    = '0;
    any_set = 1'b0;
    for (int i = 0; i < N_CFG; i++)
      if (cfg_s[i]) begin
        pick    = CFGW'(i);
        any_set = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_harv <= 1'b0;
      hcnt    <= '0;
      sel_ok  <= 1'b0;
      sel_cfg <= '0;
    end else if (!loop_on) begin
      in_harv <= 1'b0;
      hcnt    <= '0;
      sel_ok  <= 1'b0;
    end else if (tick) begin
      if (!in_harv) begin
        if (hcnt == MON_LAST) begin
          in_harv <= 1'b1;
          hcnt    <= '0;
          sel_ok  <= any_set;
          sel_cfg <= pick;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end else begin
        if (hcnt == HARV_LAST) begin
          in_harv <= 1'b0;
          hcnt    <= '0;
          sel_ok  <= 1'b0;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ratio_div5 <= 1'b0;
    else if (vlo_s)  ratio_div5 <= 1'b1;
    else if (vhi_s)  ratio_div5 <= 1'b0;

  always_comb
    case (st)
      S_OPER:   pwr_mode = 2'b01;
      S_DSLEEP: pwr_mode = 2'b10;
      S_RECOV:  pwr_mode = 2'b11;
      default:  pwr_mode = 2'b00;
    endcase

  assign hv_supply_en = (st == S_RELHV) || (st == S_RELLV) || (st == S_OPER);
  assign lv_supply_en = (st == S_RELLV) || (st == S_OPER);
  assign por_n        = (st == S_OPER);
  assign harv_monitor = loop_on && !in_harv;
  assign harv_connect = loop_on && in_harv && sel_ok;
  assign harv_cfg     = harv_connect ? sel_cfg : '0;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    pwr_mode,
  input logic          hv_supply_en,
  input logic          lv_supply_en,
  input logic          por_n,
  input logic          harv_monitor,
  input logic          harv_connect,
  input logic [CW-1:0] harv_cfg,
  input logic          ratio_div5,
  input logic          vlo_s,
  input logic          vhi_s
);

  // R3
  release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lv_supply_en) |-> $past(hv_supply_en));

  // R3
  por_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_n) |-> ($past(lv_supply_en) && pwr_mode == 2'b01));

  // R4
  oper_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_mode) == 2'b01 && pwr_mode != 2'b01) |->
      (pwr_mode == 2'b10 && !hv_supply_en && !lv_supply_en && !harv_connect));

  // R5
  recov_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b11 && $past(pwr_mode) != 2'b11) |-> $past(pwr_mode) == 2'b10);

  // R6
  mon_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    harv_monitor |-> !harv_connect);

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (harv_connect && $past(harv_connect)) |-> $stable(harv_cfg));

  // R9
  ratio_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_div5) |-> $past(vlo_s));

  // R9
  ratio_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ratio_div5) |-> $past(vhi_s));

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.CW(CFGW)) chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode),
  .hv_supply_en(hv_supply_en), .lv_supply_en(lv_supply_en), .por_n(por_n),
  .harv_monitor(harv_monitor), .harv_connect(harv_connect),
  .harv_cfg(harv_cfg), .ratio_div5(ratio_div5),
  .vlo_s(vlo_s), .vhi_s(vhi_s)
);

// File: tb/pwr_mode_seq_tb_top.sv
module pwr_mode_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic batt_hi_a = 1'b0, batt_lo_a = 1'b0, harv_avail_a = 1'b0;
  logic vout_lo_a = 1'b0, vout_hi_a = 1'b0;
  logic [2:0] cfg_above_a = 3'b000;
  logic [1:0] pwr_mode;
  logic hv_supply_en, lv_supply_en, por_n, harv_monitor, harv_connect, ratio_div5;
  logic [1:0] harv_cfg;

  always #5 clk = ~clk;

  pwr_mode_seq #(
    .N_CFG(3), .STABLE_TICKS(2), .REL_TICKS(2), .MON_TICKS(3), .HARV_TICKS(5)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .batt_hi_a(batt_hi_a), .batt_lo_a(batt_lo_a), .harv_avail_a(harv_avail_a),
    .vout_lo_a(vout_lo_a), .vout_hi_a(vout_hi_a), .cfg_above_a(cfg_above_a),
    .pwr_mode(pwr_mode), .hv_supply_en(hv_supply_en), .lv_supply_en(lv_supply_en),
    .por_n(por_n), .harv_monitor(harv_monitor), .harv_connect(harv_connect),
    .harv_cfg(harv_cfg), .ratio_div5(ratio_div5)
  );

  typedef struct {
    string      tag;
    logic [9:0] val;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      logic [9:0] act;
      e = exp_q.pop_front();
      act = {pwr_mode, hv_supply_en, lv_supply_en, por_n, harv_monitor,
             harv_connect, harv_cfg, ratio_div5};
      n_cmp++;
      if (act !== e.val) begin
        n_bad++;
        $display("FAIL %s: actual %b expected %b (mode,hv,lv,por_n,mon,conn,cfg,div5)",
                 e.tag, act, e.val);
      end
    end
  end

  task automatic chk(input string tag, input logic [1:0] m, input logic hv,
                     input logic lv, input logic pr, input logic mon,
                     input logic conn, input logic [1:0] cf, input logic d5);
    exp_t e;
    e.tag = tag;
    e.val = {m, hv, lv, pr, mon, conn, cf, d5};
    exp_q.push_back(e);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", 2'b00, 0, 0, 0, 0, 0, 2'd0, 0);

    batt_hi_a = 1'b1; settle();
    chk("R2 no tick yet", 2'b00, 0, 0, 0, 0, 0, 2'd0, 0);
    ticks(1);
    batt_hi_a = 1'b0; settle();
    batt_hi_a = 1'b1; settle();
    ticks(1);
    chk("R2 count cleared by drop", 2'b00, 0, 0, 0, 0, 0, 2'd0, 0);
    ticks(1);
    chk("R3 high supply first", 2'b00, 1, 0, 0, 0, 0, 2'd0, 0);
    ticks(1);
    chk("R3 still high only", 2'b00, 1, 0, 0, 0, 0, 2'd0, 0);
    ticks(1);
    chk("R3 low supply second", 2'b00, 1, 1, 0, 0, 0, 2'd0, 0);
    ticks(2);
    chk("R3 reset released, operational", 2'b01, 1, 1, 1, 1, 0, 2'd0, 0);

    vout_lo_a = 1'b1; settle();
    chk("R9 low output sets div5", 2'b01, 1, 1, 1, 1, 0, 2'd0, 1);
    vout_lo_a = 1'b0; settle();
    chk("R9 hold in band", 2'b01, 1, 1, 1, 1, 0, 2'd0, 1);
    vout_hi_a = 1'b1; settle();
    chk("R9 high output clears", 2'b01, 1, 1, 1, 1, 0, 2'd0, 0);
    vout_hi_a = 1'b0; settle();
    chk("R9 hold after clear", 2'b01, 1, 1, 1, 1, 0, 2'd0, 0);

    cfg_above_a = 3'b011; settle();
    ticks(2);
    chk("R6 still monitoring", 2'b01, 1, 1, 1, 1, 0, 2'd0, 0);
    ticks(1);
    chk("R7 pick index 1", 2'b01, 1, 1, 1, 0, 1, 2'd1, 0);
    cfg_above_a = 3'b111; settle();
    ticks(1);
    chk("R7 held during harvest", 2'b01, 1, 1, 1, 0, 1, 2'd1, 0);
    ticks(4);
    chk("R6 back to monitor", 2'b01, 1, 1, 1, 1, 0, 2'd0, 0);
    ticks(3);
    chk("R7 pick index 2", 2'b01, 1, 1, 1, 0, 1, 2'd2, 0);
    cfg_above_a = 3'b000; settle();
    ticks(8);
    chk("R8 none set, disconnected", 2'b01, 1, 1, 1, 0, 0, 2'd0, 0);
    cfg_above_a = 3'b001; settle();
    ticks(8);
    chk("R7 pick index 0", 2'b01, 1, 1, 1, 0, 1, 2'd0, 0);

    batt_hi_a = 1'b0; batt_lo_a = 1'b1; settle();
    chk("R4 deep sleep overrides harvest", 2'b10, 0, 0, 0, 0, 0, 2'd0, 0);
    settle();
    chk("R5 stays asleep without harvest", 2'b10, 0, 0, 0, 0, 0, 2'd0, 0);
    harv_avail_a = 1'b1; settle();
    chk("R5 recovery entered", 2'b11, 0, 0, 0, 1, 0, 2'd0, 0);
    cfg_above_a = 3'b010; settle();
    ticks(3);
    chk("R6 harvest in recovery", 2'b11, 0, 0, 0, 0, 1, 2'd1, 0);
    harv_avail_a = 1'b0; settle();
    chk("R5 back to deep sleep", 2'b10, 0, 0, 0, 0, 0, 2'd0, 0);
    harv_avail_a = 1'b1; settle();
    chk("R5 recovery again", 2'b11, 0, 0, 0, 1, 0, 2'd0, 0);
    batt_lo_a = 1'b0; batt_hi_a = 1'b1; settle();
    ticks(1);
    chk("R2 one tick in recovery", 2'b11, 0, 0, 0, 1, 0, 2'd0, 0);
    ticks(1);
    chk("R3 release from recovery", 2'b00, 1, 0, 0, 0, 0, 2'd0, 0);
    ticks(4);
    chk("R3 operational after recovery", 2'b01, 1, 1, 1, 1, 0, 2'd0, 0);

    settle();
    done = 1'b1;
    finish_run();
  end

endmodule